// File: doc/BRIEF.md
# Status Pin Selector with Lock, Fastlock, Counter-Reset and Powerdown Control

This block sits beside a dual-channel (low-band and high-band) frequency synthesizer core. It owns the one multiplexed status pin of the synthesizer. A 4-bit mode code drives that pin. The code either picks what the pin reports or turns the pin into a command. The pin can report nothing, a lock indication, or a raw divider pulse. As a command, it can close a fastlock switch to ground or hold one or both channels' counters in reset.

The block also judges lock for each channel. It watches the phase detector up/down pulses in each comparison cycle; the reference divider tick marks the end of a cycle. It also sequences powerdown for each channel. A powerdown bit is latched together with a tri-state bit. If the tri-state bit is set, powerdown takes effect at once. If it is clear, powerdown waits for the charge pump to go idle. The reference oscillator buffer is turned off only when both channels are down. Every output comes from a flop, one clock after the inputs it depends on.

Top module: `stpin_ctl`

## Requirements
- R1: After reset, every output is low. With `mode_i` = 4'b0000 the pin is driven low. The mode bits are `mode_i[3]` = high-band select A, `mode_i[2]` = low-band select A, `mode_i[1]` = high-band select B and `mode_i[0]` = low-band select B. Every output responds one clock after its inputs.
- R2: Codes 0100, 1000 and 1100 select lock display for the low band, the high band, or both together. The pin is high only while every selected channel is locked and shows no up/down activity. An active phase pulse gives a short low on the pin.
- R3: A channel becomes locked at the end of LOCK_CYCLES consecutive comparison cycles in which no up/down pulse lasts more than WIDTH_MAX clocks. A pulse exactly WIDTH_MAX clocks wide keeps lock. A channel loses lock at the end of the first cycle with a longer pulse.
- R4: The pin carries a divider pulse under these codes: x001 the low-band reference tick, x010 the high-band reference tick, x101 the low-band feedback tick, x110 the high-band feedback tick. `mode_i[3]` is ignored in all four.
- R5: Under code 0011, `fastlock_o` is high and the pin is low (switch to ground closed) only while `hb_hicur_i` is 1. Otherwise `fastlock_o` is low and the pin is high.
- R6: Codes 0111, 1011 and 1111 hold the low-band, high-band or both channels' counters in reset (`cnt_rst_o`) and force their charge pumps to high impedance (`cp_hiz_o`). The pin is low under these codes.
- R7: A powerdown load with the powerdown bit 1 and the tri-state bit 1 sets that channel's `pd_o` on the next clock.
- R8: A powerdown load with the powerdown bit 1 and the tri-state bit 0 leaves `pd_o` low until the channel's `cp_idle_i` is seen high. `pd_o` rises the clock after that.
- R9: A powerdown load with the powerdown bit 0 clears `pd_o` on the next clock and cancels any pending synchronous powerdown.
- R10: `osc_off_o` is high only while both channels are powered down.
- R11: A powered-down channel holds its counters in reset (`cnt_rst_o` high). It also has its lock cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 4 | Pin mode code (bit order in R1) |
| hb_hicur_i | input | 1 | High-band charge-pump high-current bit |
| ph_up_i | input | 2 | Phase detector up pulse per channel (0 low band, 1 high band) |
| ph_dn_i | input | 2 | Phase detector down pulse per channel |
| ref_tick_i | input | 2 | Reference divider output pulse per channel |
| fb_tick_i | input | 2 | Feedback divider output pulse per channel |
| cp_idle_i | input | 2 | Charge pump idle (tri-state reached) per channel |
| tri_bit_i | input | 2 | Latched tri-state bit per channel |
| pd_bit_i | input | 2 | Powerdown bit value being latched per channel |
| pd_load_i | input | 2 | One-clock strobe: powerdown bit latched |
| pin_o | output | 1 | Status pin level |
| fastlock_o | output | 1 | Fastlock switch and high-current enable |
| cnt_rst_o | output | 2 | Counter reset per channel |
| cp_hiz_o | output | 2 | Charge pump forced high impedance per channel |
| pd_o | output | 2 | Powerdown request per channel |
| osc_off_o | output | 1 | Reference oscillator buffer disable |

## Verification
The lock logic gets runs of clean comparison cycles, which separate "locked after exactly LOCK_CYCLES ticks" from one tick too early. It then gets pulses of exactly WIDTH_MAX and WIDTH_MAX+1 clocks, which separate the keep case from the drop case. The combined lock code is tried with one channel locked and the other not, so a logical OR would be caught. Each divider code is pulsed on its own source with `mode_i[3]` set both ways, which catches swapped channels and a top bit that should be ignored. The powerdown tests hold the charge pump busy for several clocks before releasing it, which separates synchronous from asynchronous entry. A pending entry is also cancelled by a power-up load.

// File: rtl/stpin_pkg.sv
package stpin_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_LB  = 0;
  localparam int CH_HB  = 1;

  typedef enum logic [2:0] {
    PIN_OFF, PIN_LOCK, PIN_REF, PIN_FB, PIN_FAST, PIN_RST
  } pin_fn_e;

  typedef struct packed {
    pin_fn_e            fn;
    logic [NUM_CH-1:0]  chan;   // bit CH_HB / CH_LB
  } mode_dec_t;

  // mode[3]=hb A, mode[2]=lb A, mode[1]=hb B, mode[0]=lb B
  function automatic mode_dec_t decode_mode(input logic [3:0] m);
    mode_dec_t d;
    d.fn   = PIN_OFF;
    d.chan = '0;
    case (m[1:0])
      2'b00: if (m[3:2] != 2'b00) begin
        d.fn   = PIN_LOCK;
        d.chan = {m[3], m[2]};
      end
      2'b01: begin
        d.fn   = m[2] ? PIN_FB : PIN_REF;
        d.chan = 2'b01;
      end
      2'b10: begin
        d.fn   = m[2] ? PIN_FB : PIN_REF;
        d.chan = 2'b10;
      end
      default: begin
        if (m[3:2] == 2'b00) d.fn = PIN_FAST;
        else begin
          d.fn   = PIN_RST;
          d.chan = {m[3], m[2]};
        end
      end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/stpin_lock_det.sv
module stpin_lock_det #(
  parameter int WIDTH_MAX   = 4,
  parameter int LOCK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic ph_act_i,
  input  logic tick_i,
  output logic lock_o
);
  localparam int WCW = $clog2(WIDTH_MAX + 2);
  localparam int GCW = $clog2(LOCK_CYCLES + 1);
  localparam logic [WCW-1:0] W_SAT = WCW'(WIDTH_MAX + 1);
  localparam logic [WCW-1:0] W_LIM = WCW'(WIDTH_MAX);
  localparam logic [GCW-1:0] G_LAST = GCW'(LOCK_CYCLES - 1);

  logic [WCW-1:0] wcnt_q;
  logic [GCW-1:0] good_q;
  logic           over_q;
  logic           lock_q;
  logic           long_now;
  logic           over_any;

  // Pulse is longer than WIDTH_MAX once WIDTH_MAX active clocks already counted
  assign long_now = ph_act_i && (wcnt_q >= W_LIM);
  assign over_any = over_q | long_now;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wcnt_q <= '0;
      good_q <= '0;
      over_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (!ph_act_i)           wcnt_q <= '0;
      else if (wcnt_q != W_SAT) wcnt_q <= wcnt_q + 1'b1;

      if (tick_i) begin
        over_q <= 1'b0;
        if (over_any) begin
          good_q <= '0;
          lock_q <= 1'b0;
        end else if (good_q >= G_LAST) begin
          lock_q <= 1'b1;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end else begin
        over_q <= over_any;
      end
    end
  end

  assign lock_o = lock_q;

  // R3: lock can only be granted at the end of a comparison cycle
  assert_lock_rise_at_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(tick_i));
endmodule

// File: rtl/stpin_pwr_seq.sv
module stpin_pwr_seq (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic bit_i,
  input  logic tri_i,
  input  logic idle_i,
  output logic pd_o
);
  logic pd_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (load_i) begin
      if (!bit_i) begin
        pd_q   <= 1'b0;
        pend_q <= 1'b0;
      end else if (tri_i) begin
        pd_q   <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        pend_q <= 1'b1;
      end
    end else if (pend_q && idle_i) begin
      pd_q   <= 1'b1;
      pend_q <= 1'b0;
    end
  end

  assign pd_o = pd_q;

  assert_async_enter_R7: assert property (@(posedge clk) disable iff (rst)
    (load_i && bit_i && tri_i) |=> pd_q);

  assert_powerup_now_R9: assert property (@(posedge clk) disable iff (rst)
    (load_i && !bit_i) |=> !pd_q);

  // R8: entry without the tri-state bit needs an idle charge pump
  assert_sync_waits_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_q) |-> ($past(idle_i) || $past(load_i && tri_i)));
endmodule

// File: rtl/stpin_pin_sel.sv
module stpin_pin_sel
  import stpin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        mode_i,
  input  logic              hicur_i,
  input  logic [NUM_CH-1:0] lock_i,
  input  logic [NUM_CH-1:0] act_i,
  input  logic [NUM_CH-1:0] ref_tick_i,
  input  logic [NUM_CH-1:0] fb_tick_i,
  output logic              pin_o,
  output logic              fastlock_o,
  output logic [NUM_CH-1:0] rst_mode_o
);
  mode_dec_t         dec;
  logic              lock_ok;
  logic              pin_d;
  logic              fl_d;
  logic [NUM_CH-1:0] rst_d;
  logic              pin_q;
  logic              fl_q;
  logic [NUM_CH-1:0] rst_q;

  always_comb begin
    dec     = decode_mode(mode_i);
    lock_ok = 1'b1;
    for (int c = 0; c < NUM_CH; c++) begin
      if (dec.chan[c] && !(lock_i[c] && !act_i[c])) lock_ok = 1'b0;
    end
    pin_d = 1'b0;
    fl_d  = 1'b0;
    rst_d = '0;
    case (dec.fn)
      PIN_LOCK: pin_d = lock_ok;
      PIN_REF:  pin_d = |(ref_tick_i & dec.chan);
      PIN_FB:   pin_d = |(fb_tick_i & dec.chan);
      PIN_FAST: begin
        fl_d  = hicur_i;
        pin_d = !hicur_i;
      end
      PIN_RST:  rst_d = dec.chan;
      default:  pin_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      fl_q  <= 1'b0;
      rst_q <= '0;
    end else begin
      pin_q <= pin_d;
      fl_q  <= fl_d;
      rst_q <= rst_d;
    end
  end

  assign pin_o      = pin_q;
  assign fastlock_o = fl_q;
  assign rst_mode_o = rst_q;

  assert_off_pin_low_R1: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 4'b0000) |=> !pin_q);

  assert_fast_switch_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 4'b0011 && hicur_i) |=> (fl_q && !pin_q));
endmodule

// File: rtl/stpin_ctl.sv
module stpin_ctl
  import stpin_pkg::*;
#(
  parameter int WIDTH_MAX   = 4,
  parameter int LOCK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] mode_i,
  input  logic       hb_hicur_i,
  input  logic [1:0] ph_up_i,
  input  logic [1:0] ph_dn_i,
  input  logic [1:0] ref_tick_i,
  input  logic [1:0] fb_tick_i,
  input  logic [1:0] cp_idle_i,
  input  logic [1:0] tri_bit_i,
  input  logic [1:0] pd_bit_i,
  input  logic [1:0] pd_load_i,
  output logic       pin_o,
  output logic       fastlock_o,
  output logic [1:0] cnt_rst_o,
  output logic [1:0] cp_hiz_o,
  output logic [1:0] pd_o,
  output logic       osc_off_o
);
  logic [NUM_CH-1:0] act;
  logic [NUM_CH-1:0] lock;
  logic [NUM_CH-1:0] rst_mode;
  logic [NUM_CH-1:0] pd;

  assign act = ph_up_i | ph_dn_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    stpin_lock_det #(
      .WIDTH_MAX  (WIDTH_MAX),
      .LOCK_CYCLES(LOCK_CYCLES)
    ) u_lock (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (cnt_rst_o[c]),
      .ph_act_i(act[c]),
      .tick_i  (ref_tick_i[c]),
      .lock_o  (lock[c])
    );

    stpin_pwr_seq u_pwr (
      .clk   (clk),
      .rst   (rst),
      .load_i(pd_load_i[c]),
      .bit_i (pd_bit_i[c]),
      .tri_i (tri_bit_i[c]),
      .idle_i(cp_idle_i[c]),
      .pd_o  (pd[c])
    );
  end

  stpin_pin_sel u_sel (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .hicur_i   (hb_hicur_i),
    .lock_i    (lock),
    .act_i     (act),
    .ref_tick_i(ref_tick_i),
    .fb_tick_i (fb_tick_i),
    .pin_o     (pin_o),
    .fastlock_o(fastlock_o),
    .rst_mode_o(rst_mode)
  );

  assign cnt_rst_o = rst_mode | pd;
  assign cp_hiz_o  = rst_mode;
  assign pd_o      = pd;
  assign osc_off_o = &pd;

  // R10: oscillator off implies each channel is down
  assert_osc_needs_both_R10: assert property (@(posedge clk) disable iff (rst)
    osc_off_o |-> (pd_o == 2'b11));
endmodule

// File: tb/stpin_ctl_tb.sv
`timescale 1ns/1ps
module stpin_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] mode_i = '0;
  logic       hb_hicur_i = 1'b0;
  logic [1:0] ph_up_i = '0, ph_dn_i = '0, ref_tick_i = '0, fb_tick_i = '0;
  logic [1:0] cp_idle_i = '0, tri_bit_i = '0, pd_bit_i = '0, pd_load_i = '0;
  logic       pin_o, fastlock_o, osc_off_o;
  logic [1:0] cnt_rst_o, cp_hiz_o, pd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stpin_ctl #(.WIDTH_MAX(4), .LOCK_CYCLES(4)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .hb_hicur_i(hb_hicur_i),
    .ph_up_i(ph_up_i), .ph_dn_i(ph_dn_i), .ref_tick_i(ref_tick_i),
    .fb_tick_i(fb_tick_i), .cp_idle_i(cp_idle_i), .tri_bit_i(tri_bit_i),
    .pd_bit_i(pd_bit_i), .pd_load_i(pd_load_i), .pin_o(pin_o),
    .fastlock_o(fastlock_o), .cnt_rst_o(cnt_rst_o), .cp_hiz_o(cp_hiz_o),
    .pd_o(pd_o), .osc_off_o(osc_off_o));

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
  endtask

  // one comparison cycle: up pulse of w0 / w1 clocks, idle, then tick both
  task automatic run_cycle(int w0, int w1);
    int wm = (w0 > w1) ? w0 : w1;
    for (int i = 0; i < wm; i++) begin
      ph_up_i[0] = (i < w0);
      ph_up_i[1] = (i < w1);
      step(1);
    end
    ph_up_i = '0;
    step(2);
    ref_tick_i = 2'b11;
    step(1);
    ref_tick_i = 2'b00;
    step(2);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 pin after reset", {7'b0, pin_o}, 8'd0);
    chk("R1 outputs after reset",
        {1'b0, fastlock_o, cnt_rst_o, pd_o, osc_off_o, 1'b0}, 8'd0);
    ref_tick_i = 2'b11;  // off mode ignores sources
    step(1);
    chk("R1 off mode pin low", {7'b0, pin_o}, 8'd0);
    ref_tick_i = 2'b00;
  endtask

  task automatic t_dividers();
    for (int top = 0; top < 2; top++) begin
      mode_i = {top[0], 3'b001};
      ref_tick_i = 2'b01; step(1);
      chk("R4 lb ref tick", {7'b0, pin_o}, 8'd1);
      ref_tick_i = 2'b10; step(1);
      chk("R4 lb ref ignores hb", {7'b0, pin_o}, 8'd0);
      mode_i = {top[0], 3'b010};
      ref_tick_i = 2'b10; step(1);
      chk("R4 hb ref tick", {7'b0, pin_o}, 8'd1);
      ref_tick_i = 2'b00;
      mode_i = {top[0], 3'b101};
      fb_tick_i = 2'b01; step(1);
      chk("R4 lb fb tick", {7'b0, pin_o}, 8'd1);
      fb_tick_i = 2'b10; step(1);
      chk("R4 lb fb ignores hb", {7'b0, pin_o}, 8'd0);
      mode_i = {top[0], 3'b110};
      fb_tick_i = 2'b10; step(1);
      chk("R4 hb fb tick", {7'b0, pin_o}, 8'd1);
      fb_tick_i = 2'b00; step(1);
      chk("R4 hb fb idle", {7'b0, pin_o}, 8'd0);
    end
  endtask

  task automatic t_lock();
    do_reset();
    mode_i = 4'b0100;
    for (int i = 0; i < 3; i++) run_cycle(0, 0);
    chk("R3 not locked after 3 cycles", {7'b0, pin_o}, 8'd0);
    run_cycle(0, 0);
    chk("R3 locked after 4 cycles", {7'b0, pin_o}, 8'd1);
    ph_dn_i[0] = 1'b1; step(1);
    chk("R2 brief low on phase pulse", {7'b0, pin_o}, 8'd0);
    ph_dn_i[0] = 1'b0; step(1);
    chk("R2 high again after pulse", {7'b0, pin_o}, 8'd1);
    run_cycle(4, 0);
    chk("R3 width at limit keeps lock", {7'b0, pin_o}, 8'd1);
    run_cycle(5, 0);
    chk("R3 width over limit drops lock", {7'b0, pin_o}, 8'd0);
    mode_i = 4'b1100; step(1);
    chk("R2 both mode needs both locked", {7'b0, pin_o}, 8'd0);
    mode_i = 4'b1000; step(1);
    chk("R2 hb lock shown", {7'b0, pin_o}, 8'd1);
    mode_i = 4'b1100;
    for (int i = 0; i < 4; i++) run_cycle(0, 0);
    chk("R2 both locked", {7'b0, pin_o}, 8'd1);
  endtask

  task automatic t_fastlock();
    mode_i = 4'b0011; hb_hicur_i = 1'b0; step(1);
    chk("R5 switch open without high current", {6'b0, fastlock_o, pin_o}, 8'd1);
    hb_hicur_i = 1'b1; step(1);
    chk("R5 switch closed with high current", {6'b0, fastlock_o, pin_o}, 8'd2);
    hb_hicur_i = 1'b0;
  endtask

  task automatic t_counter_reset();
    mode_i = 4'b0111; step(1);
    chk("R6 lb reset", {3'b0, pin_o, cnt_rst_o, cp_hiz_o}, 8'b0101);
    mode_i = 4'b1011; step(1);
    chk("R6 hb reset", {3'b0, pin_o, cnt_rst_o, cp_hiz_o}, 8'b1010);
    mode_i = 4'b1111; step(1);
    chk("R6 both reset", {3'b0, pin_o, cnt_rst_o, cp_hiz_o}, 8'b1111);
    mode_i = 4'b1000; step(1);
    chk("R6 reset released", {4'b0, cnt_rst_o, cp_hiz_o}, 8'd0);
  endtask

  task automatic pd_load(int ch, logic b, logic t);
    pd_bit_i[ch] = b; tri_bit_i[ch] = t; pd_load_i[ch] = 1'b1;
    step(1);
    pd_load_i = '0;
  endtask

  task automatic t_powerdown();
    do_reset();
    mode_i = 4'b1000;
    pd_load(1, 1'b1, 1'b1);
    chk("R7 async entry next clock", {6'b0, pd_o}, 8'b10);
    chk("R11 down channel counters reset", {6'b0, cnt_rst_o}, 8'b10);
    chk("R10 osc on with one channel up", {7'b0, osc_off_o}, 8'd0);
    cp_idle_i[0] = 1'b0;
    pd_load(0, 1'b1, 1'b0);
    step(3);
    chk("R8 sync waits for idle", {6'b0, pd_o}, 8'b10);
    cp_idle_i[0] = 1'b1; step(1);
    chk("R8 sync enters after idle", {6'b0, pd_o}, 8'b11);
    chk("R10 osc off with both down", {7'b0, osc_off_o}, 8'd1);
    pd_load(1, 1'b0, 1'b1);
    chk("R9 power-up next clock", {6'b0, pd_o}, 8'b01);
    chk("R10 osc back on", {7'b0, osc_off_o}, 8'd0);
    pd_load(0, 1'b0, 1'b0);
    cp_idle_i[0] = 1'b0;
    pd_load(0, 1'b1, 1'b0);
    pd_load(0, 1'b0, 1'b0);
    cp_idle_i[0] = 1'b1; step(2);
    chk("R9 power-up cancels pending", {6'b0, pd_o}, 8'b00);
    mode_i = 4'b0100;
    for (int i = 0; i < 4; i++) run_cycle(0, 0);
    pd_load(0, 1'b1, 1'b1); step(1);
    pd_load(0, 1'b0, 1'b1); step(1);
    chk("R11 lock cleared by powerdown", {7'b0, pin_o}, 8'd0);
  endtask

  initial begin
    step(1);
    t_reset_state();
    t_dividers();
    t_lock();
    t_fastlock();
    t_counter_reset();
    t_powerdown();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule